// File: doc/BRIEF.md
# Interrupt Event Register Group

This block gathers hardware interrupt events into a small group of software-visible registers and turns them into one interrupt line per source. Each source may be one or more bits wide. The sources are packed into a single register word. Events latch into a state register. Software clears the state by writing ones. An enable register gates which state bits may raise an interrupt line. A write-only test register lets software force state bits to one, so the interrupt path can be exercised without real events.

Software reaches the group through a plain port with a byte address, a write strobe and write data. Reads are combinational from the same address. The interrupt outputs are registered. The source count and the width of each source are parameters. The packed total must fit in one register word.

Top module: `irq_regfile`

## Requirements
- R1: The state register is at byte address 0x0, the enable register at 0x4 and the test register at 0x8. Writes to any other address change nothing, and reads of any other address return 0.
- R2: Source i takes the bits starting at the sum of the widths of sources 0..i-1, beginning at bit 0. With the default widths (1, 2, 1, 3) the sources sit at bits [0], [2:1], [3] and [6:4]. Register bits above the packed total read 0.
- R3: A write to the state register clears every state bit whose write-data bit is 1. Write-data bits of 0 leave their state bits unchanged.
- R4: An event input bit that is high at a clock edge sets its state bit at that edge. When a clear hits the same bit in the same cycle, the set wins.
- R5: The enable register reads back the value last written to it, limited to the packed bits.
- R6: A write to the test register forces each state bit whose data bit is 1 to 1 at the clock edge that follows the write edge. Data bits of 0 have no effect.
- R7: A read of the test register returns 0.
- R8: Interrupt output i equals the OR over its bits of state AND enable. It is registered, so it follows the state and enable values one clock edge later.
- R9: An active-low asynchronous reset clears state, enable, any pending test force and all interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | TOT_W | Hardware event bits, packed like the state register |
| wrEn | input | 1 | Software write strobe |
| addr | input | ADDR_W | Byte address of the register accessed |
| wrData | input | REG_W | Software write data |
| rdData | output | REG_W | Read data for `addr`, combinational |
| irqOut | output | NUM_IRQ | One registered interrupt line per source |

## Verification
Two things can land on the same state bit in one cycle: a hardware event that sets the bit and a software write-one that clears it. The bench provokes this by writing a one to the state register on the same edge that an event arrives on that bit. It then reads the state back and checks that the bit is still set and that the interrupt line stays high. A second overlap case is a test force that lands while the state register is being read. Here the bench checks that the forced bits appear exactly one edge after the test write, and not on the write edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Byte offsets of the three registers
  localparam int unsigned OFF_STATE  = 0;
  localparam int unsigned OFF_ENABLE = 4;
  localparam int unsigned OFF_TEST   = 8;

  // Width list: 8 bits per source, source 0 in the low byte
  localparam int unsigned MAX_SRC = 32;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATE  = 2'd1,
    SEL_ENABLE = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    wrState;
    logic    wrEnable;
    logic    wrTest;
    rd_sel_e rdSel;
  } irq_strobe_t;

  function automatic int unsigned width_sum(int unsigned n, logic [8*MAX_SRC-1:0] w);
    int unsigned s = 0;
    for (int i = 0; i < MAX_SRC; i++) begin
      if (i < n) s += int'(w[i*8 +: 8]);
    end
    return s;
  endfunction

  function automatic int unsigned lsb_of(int unsigned idx, logic [8*MAX_SRC-1:0] w);
    int unsigned s = 0;
    for (int i = 0; i < MAX_SRC; i++) begin
      if (i < idx) s += int'(w[i*8 +: 8]);
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output irq_strobe_t       strb
);

  localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'(OFF_STATE);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_TEST   = ADDR_W'(OFF_TEST);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_NONE;
    strb.wrState  = wrEn && (addr == A_STATE);
    strb.wrEnable = wrEn && (addr == A_ENABLE);
    strb.wrTest   = wrEn && (addr == A_TEST);
    if (addr == A_STATE)       strb.rdSel = SEL_STATE;
    else if (addr == A_ENABLE) strb.rdSel = SEL_ENABLE;
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int unsigned               REG_W      = 32,
  parameter int unsigned               NUM_IRQ    = 4,
  parameter logic [8*MAX_SRC-1:0]      SRC_WIDTHS = 256'h03010201,
  parameter int unsigned               TOT_W      = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  irq_strobe_t        strb,
  input  logic [TOT_W-1:0]   wrBits,
  input  logic [TOT_W-1:0]   evtIn,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0] irqOut
);

  logic [TOT_W-1:0]   stateQ, enQ, testVal;
  logic               testQe;
  logic [TOT_W-1:0]   clrMask, forceMask;
  logic [NUM_IRQ-1:0] hit;

  assign clrMask   = strb.wrState ? wrBits  : '0;
  assign forceMask = testQe       ? testVal : '0;

  // State: hardware set and test force beat the software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= (stateQ & ~clrMask) | evtIn | forceMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enQ <= '0;
    else if (strb.wrEnable) enQ <= wrBits;
  end

  // Test register: one-cycle qualify pulse carrying the force bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testQe  <= 1'b0;
      testVal <= '0;
    end else begin
      testQe  <= strb.wrTest;
      testVal <= strb.wrTest ? wrBits : '0;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    localparam int unsigned LO = lsb_of(i, SRC_WIDTHS);
    localparam int unsigned W  = int'(SRC_WIDTHS[i*8 +: 8]);
    assign hit[i] = |(stateQ[LO +: W] & enQ[LO +: W]);

    // A source whose enable slice is all zero cannot raise its line next cycle
    p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
      (enQ[LO +: W] == '0) |=> !irqOut[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= hit;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STATE:  rdData = REG_W'(stateQ);
      SEL_ENABLE: rdData = REG_W'(enQ);
      default:    rdData = '0;
    endcase
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stateQ & $past(evtIn)) == $past(evtIn)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrState |=> ((stateQ & $past(wrBits & ~evtIn & ~forceMask)) == '0));

  p_test_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTest |=> testQe);

  p_test_force_r6: assert property (@(posedge clk) disable iff (!rstN)
    testQe |=> ((stateQ & $past(testVal)) == $past(testVal)));

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int unsigned               REG_W      = 32,
  parameter int unsigned               ADDR_W     = 4,
  parameter int unsigned               NUM_IRQ    = 4,
  parameter logic [8*NUM_IRQ-1:0]      SRC_WIDTHS = {8'd3, 8'd1, 8'd2, 8'd1},
  parameter int unsigned               TOT_W      = width_sum(NUM_IRQ, (8*MAX_SRC)'(SRC_WIDTHS))
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOT_W-1:0]   evtIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0] irqOut
);

  localparam logic [8*MAX_SRC-1:0] WIDTHS_X = (8*MAX_SRC)'(SRC_WIDTHS);

  irq_strobe_t strb;

  if (TOT_W < REG_W) begin : g_spare
    logic unusedWrBits;
    assign unusedWrBits = ^wrData[REG_W-1:TOT_W];
  end

  irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  irq_datapath #(
    .REG_W      (REG_W),
    .NUM_IRQ    (NUM_IRQ),
    .SRC_WIDTHS (WIDTHS_X),
    .TOT_W      (TOT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrBits (wrData[TOT_W-1:0]),
    .evtIn  (evtIn),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  p_test_reads_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFF_TEST)) |-> (rdData == '0));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == '0));

endmodule

// File: tb/irq_regfile_bench.sv
module irq_regfile_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtIn = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_regfile u_irq_regfile (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [31:0] wd;
    logic [6:0]  ev;
    logic [31:0] expRd;
    logic [3:0]  expIrq;
    logic [3:0]  req;
  } vec_t;

  // Expectations are the values seen before the vector's clock edge.
  // Packing (R2): src0 bit0, src1 bits 2:1, src2 bit3, src3 bits 6:4
  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h00, 4'b0000, 4'd9}, // R9 idle after reset
    '{1'b0, 4'h0, 32'h0,        7'h05, 32'h00, 4'b0000, 4'd4}, // R4 events on bits 0,2
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h05, 4'b0000, 4'd4}, // R4 latched
    '{1'b1, 4'h4, 32'hFFFFFFFF, 7'h00, 32'h00, 4'b0000, 4'd8}, // R8 masked while enable 0
    '{1'b0, 4'h4, 32'h0,        7'h00, 32'h7F, 4'b0000, 4'd5}, // R5 R2 upper bits read 0
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h05, 4'b0011, 4'd8}, // R8 src0, src1 up
    '{1'b1, 4'h0, 32'h01,       7'h00, 32'h05, 4'b0011, 4'd3}, // R3 clear bit0
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h04, 4'b0011, 4'd3}, // R3 only bit0 gone
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h04, 4'b0010, 4'd8}, // R8 src0 drops
    '{1'b1, 4'h0, 32'h04,       7'h04, 32'h04, 4'b0010, 4'd4}, // R4 set vs clear
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h04, 4'b0010, 4'd4}, // R4 set won
    '{1'b1, 4'h8, 32'h48,       7'h00, 32'h00, 4'b0010, 4'd7}, // R7 test write, reads 0
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h04, 4'b0010, 4'd6}, // R6 not yet forced
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h4C, 4'b0010, 4'd6}, // R6 bits 3,6 forced
    '{1'b0, 4'h8, 32'h0,        7'h00, 32'h00, 4'b1110, 4'd7}, // R7 R8
    '{1'b1, 4'h4, 32'h08,       7'h00, 32'h7F, 4'b1110, 4'd5}, // R5 enable only src2
    '{1'b0, 4'h4, 32'h0,        7'h00, 32'h08, 4'b1110, 4'd5}, // R5
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h4C, 4'b0100, 4'd8}, // R8 masking
    '{1'b1, 4'h0, 32'hFFFFFFFF, 7'h00, 32'h4C, 4'b0100, 4'd3}, // R3 clear all
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h00, 4'b0100, 4'd8}, // R8 lag one edge
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h00, 4'b0000, 4'd8}, // R8
    '{1'b1, 4'hC, 32'hFF,       7'h00, 32'h00, 4'b0000, 4'd1}, // R1 unmapped write/read
    '{1'b0, 4'h4, 32'h0,        7'h00, 32'h08, 4'b0000, 4'd1}, // R1 enable untouched
    '{1'b0, 4'h0, 32'h0,        7'h7F, 32'h00, 4'b0000, 4'd2}, // R2 all sources fire
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h7F, 4'b0000, 4'd2}, // R2
    '{1'b0, 4'h0, 32'h0,        7'h00, 32'h7F, 4'b0100, 4'd8}  // R8 only src2 enabled
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [6:0] e);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; evtIn = e;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R9 reset state
    #1;
    addr = 4'h0; #1; chk("R9 state in reset", rdData, 32'h0);
    chk("R9 irq in reset", {28'h0, irqOut}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].wr, TBL[i].a, TBL[i].wd, TBL[i].ev);
      #1;
      chk($sformatf("R%0d vec %0d rdData", TBL[i].req, i), rdData, TBL[i].expRd);
      chk($sformatf("R%0d vec %0d irqOut", TBL[i].req, i), {28'h0, irqOut}, {28'h0, TBL[i].expIrq});
    end

    // R6: test write of zeros forces nothing (state 7F -> clear first)
    step(1'b1, 4'h0, 32'hFFFFFFFF, 7'h00);
    step(1'b1, 4'h8, 32'h0, 7'h00);
    step(1'b0, 4'h0, 32'h0, 7'h00);
    step(1'b0, 4'h0, 32'h0, 7'h00);
    #1; chk("R6 zero test write", rdData, 32'h0);

    // R3: writing zeros to state keeps bits
    step(1'b0, 4'h0, 32'h0, 7'h12);
    step(1'b1, 4'h0, 32'h0, 7'h00);
    step(1'b0, 4'h0, 32'h0, 7'h00);
    #1; chk("R3 zero write keeps state", rdData, 32'h12);

    // R9: asynchronous reset mid-run clears everything
    step(1'b0, 4'h8, 32'h0, 7'h00);
    step(1'b1, 4'h8, 32'h70, 7'h00);
    #1 rstN = 1'b0; wrEn = 1'b0;
    #0.5;
    addr = 4'h0; #0.2; chk("R9 state after reset", rdData, 32'h0);
    addr = 4'h4; #0.2; chk("R9 enable after reset", rdData, 32'h0);
    chk("R9 irq after reset", {28'h0, irqOut}, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1; addr = 4'h0;
    step(1'b0, 4'h0, 32'h0, 7'h00);
    #1; chk("R9 no pending force after reset", rdData, 32'h0);

    finishRun();
  end

endmodule